// File: doc/BRIEF.md
# Burst-of-two separate-I/O SRAM core

This block is a synthesizable behavioural model of a pipelined synchronous SRAM. It has a write-data input and a read-data output that are separate, and one address bus that both paths share. Every command moves two words in a fixed two-beat burst. The core runs on a single beat clock. An internal phase bit splits that clock into command periods of two beats: the even beat is the command edge, and each beat carries one data word.

A read command returns its first word on the command edge that follows it and its second word on the next beat. Read commands on consecutive command edges therefore give an unbroken data stream. A write registers its address at the command edge and takes its two data beats in the following command period (late write). Per-lane enables gate each 9-bit lane of the word. When no read is pending, the output-enable indication drops. An echo strobe toggles on every beat and marks which word of a burst is on the bus.

Top module: `sram_b2_core`

## Requirements
- R1: Commands are sampled only on command edges, which are the even beats counted from the first clock edge after reset release. The values of load_i, rw_i and addr_i on odd beats have no effect.
- R2: At a command edge, load_i=1 with rw_i=1 starts a read and load_i=1 with rw_i=0 starts a write. With load_i=0 no access starts.
- R3: The first word of a burst uses the captured address A. The second word uses A with bit 0 inverted.
- R4: Read data for a command at edge t is on rdata_o after edge t+2 (first word) and after edge t+3 (second word). oe_o is 1 for both of those beats.
- R5: Reads on consecutive command edges keep oe_o at 1 and present valid data on every beat, with no gap.
- R6: A burst that has started always completes both beats. At a command edge with no read pending, oe_o falls to 0.
- R7: Write data for a write command at edge t is sampled at edges t+2 (word at A) and t+3 (word at A with bit 0 inverted). Write data on any other beat is ignored.
- R8: For write beats, a bw_ni bit of 0 writes lane k, which is bits 9k+8 down to 9k. A bw_ni bit of 1 leaves that lane unchanged.
- R9: A read returns every write beat sampled before its own beat, including data from a write issued on the command edge just before the read.
- R10: echo_o is 0 in reset and toggles on every beat. It is 1 while the first word of a burst is on the bus and 0 while the second is.
- R11: Reset forces oe_o and echo_o to 0 and discards pending commands. A read issued before reset produces no output after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Beat clock; every second rising edge is a command edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Command request, sampled on command edges |
| rw_i | input | 1 | 1 selects read, 0 selects write |
| addr_i | input | ADDR_W | Shared word address for reads and writes |
| wdata_i | input | DATA_W | Write data beat |
| bw_ni | input | DATA_W/9 | Active-low write enable per 9-bit lane |
| rdata_o | output | DATA_W | Read data beat |
| oe_o | output | 1 | High while rdata_o carries burst data |
| echo_o | output | 1 | Beat strobe aligned to read data |

## Verification
The hardest situation to reach is the one where write data for one command and the address of the next command are both live on the same beats. A read follows right behind a write to the same burst, while the bus lines that should be ignored are driven with active-looking values. The stimulus covers this in two ways. Directed write-then-read pairs land on the same address, including partial lane masks and odd base addresses. Random mixes drive a plausible command, random lane masks and random data on every odd beat and on every idle data beat, so any sampling on the wrong beat corrupts the checked readback.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic {
    PH_CMD   = 1'b0,
    PH_BEAT1 = 1'b1
  } phase_e;
endpackage

// File: rtl/sram_b2_ctrl.sv
module sram_b2_ctrl
  import sram_b2_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  output phase_e            ph_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  phase_e            ph_q;
  logic              rd_pend_q, rd_act_q, wr_pend_q, wr_act_q;
  logic [ADDR_W-1:0] rd_base_q, rd_hold_q, wr_base_q, wr_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_CMD;
      rd_pend_q <= 1'b0;
      rd_act_q  <= 1'b0;
      wr_pend_q <= 1'b0;
      wr_act_q  <= 1'b0;
      rd_base_q <= '0;
      rd_hold_q <= '0;
      wr_base_q <= '0;
      wr_hold_q <= '0;
    end else begin
      ph_q <= (ph_q == PH_CMD) ? PH_BEAT1 : PH_CMD;
      if (ph_q == PH_CMD) begin
        // stage 1: new command; stage 2: previous command enters its data period
        rd_pend_q <= load_i & rw_i;
        wr_pend_q <= load_i & ~rw_i;
        rd_base_q <= addr_i;
        wr_base_q <= addr_i;
        rd_act_q  <= rd_pend_q;
        wr_act_q  <= wr_pend_q;
        rd_hold_q <= rd_base_q;
        wr_hold_q <= wr_base_q;
      end
    end
  end

  assign ph_o      = ph_q;
  assign rd_en_o   = (ph_q == PH_CMD) ? rd_pend_q : rd_act_q;
  assign wr_en_o   = (ph_q == PH_CMD) ? wr_pend_q : wr_act_q;
  assign rd_addr_o = (ph_q == PH_CMD) ? rd_base_q : {rd_hold_q[ADDR_W-1:1], ~rd_hold_q[0]};
  assign wr_addr_o = (ph_q == PH_CMD) ? wr_base_q : {wr_hold_q[ADDR_W-1:1], ~wr_hold_q[0]};
endmodule

// File: rtl/sram_b2_mem.sv
module sram_b2_mem
  import sram_b2_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 18
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W/LANE_W-1:0] bw_ni,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [DATA_W-1:0]        rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i && !bw_ni[k])
        mem_q[waddr_i][k*LANE_W +: LANE_W] <= wdata_i[k*LANE_W +: LANE_W];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sram_b2_out.sv
module sram_b2_out
  import sram_b2_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            ph_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] rword_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o,
  output logic              echo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      oe_o    <= 1'b0;
      echo_o  <= 1'b0;
    end else begin
      oe_o   <= rd_en_i;
      echo_o <= (ph_i == PH_CMD);
      if (rd_en_i) rdata_o <= rword_i;
    end
  end
endmodule

// File: rtl/sram_b2_core.sv
module sram_b2_core
  import sram_b2_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     rw_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W/LANE_W-1:0] bw_ni,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     oe_o,
  output logic                     echo_o
);
  phase_e            ph;
  logic              rd_en, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rword;

  sram_b2_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk_i, .rst_ni, .load_i, .rw_i, .addr_i,
    .ph_o(ph), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr)
  );

  sram_b2_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk_i, .we_i(wr_en), .waddr_i(wr_addr), .wdata_i, .bw_ni,
    .raddr_i(rd_addr), .rdata_o(rword)
  );

  sram_b2_out #(.DATA_W(DATA_W)) out_i (
    .clk_i, .rst_ni, .ph_i(ph), .rd_en_i(rd_en), .rword_i(rword),
    .rdata_o, .oe_o, .echo_o
  );
endmodule

// File: rtl/sram_b2_chk.sv
module sram_b2_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic load_i,
  input logic rw_i,
  input logic oe_o,
  input logic echo_o
);
  // R10: strobe toggles every beat
  assert_echo_toggle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (echo_o != $past(echo_o)));

  // R4: burst starts with the first-word strobe level
  assert_first_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> echo_o);

  // R6: a started burst lasts two beats
  assert_burst_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |=> oe_o);

  // R2 / R1: output only follows a read sampled on a command edge
  assert_read_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(load_i && rw_i && !echo_o, 3));

  // R11: output disabled while in reset
  assert_reset_quiet_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (!oe_o && !echo_o));
endmodule

bind sram_b2_core sram_b2_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .rw_i(rw_i),
  .oe_o(oe_o), .echo_o(echo_o)
);

// File: tb/sram_b2_core_tb.sv
module sram_b2_core_tb_top;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 18;
  localparam int unsigned LN = DW / 9;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0, rw_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [LN-1:0] bw_ni = '1;
  logic [DW-1:0] rdata_o;
  logic          oe_o, echo_o;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic          prev_rd = 1'b0, prev_wr = 1'b0;
  logic [AW-1:0] prev_ra = '0, prev_wa = '0;
  logic [DW-1:0] prev_d0 = '0, prev_d1 = '0;
  logic [LN-1:0] prev_b0 = '1, prev_b1 = '1;

  sram_b2_core #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i, .rst_ni, .load_i, .rw_i, .addr_i, .wdata_i, .bw_ni,
    .rdata_o, .oe_o, .echo_o
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [AW-1:0] pair_of(input logic [AW-1:0] a);
    return {a[AW-1:1], ~a[0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] b);
    for (int k = 0; k < LN; k++)
      if (!b[k]) ref_mem[a][k*9 +: 9] = d[k*9 +: 9];
  endtask

  // one command period: command + write beat 0, then beat 1 with junk on command pins
  task automatic run_cycle(input logic ld, input logic rw, input logic [AW-1:0] a,
                           input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                           input logic [LN-1:0] b0, input logic [LN-1:0] b1);
    logic r, w;
    logic [AW-1:0] ra, wa;
    logic [DW-1:0] e0, e1;
    r = prev_rd; w = prev_wr; ra = prev_ra; wa = prev_wa;
    @(negedge clk_i);
    load_i = ld; rw_i = rw; addr_i = a;
    wdata_i = w ? prev_d0 : DW'($urandom);
    bw_ni   = w ? prev_b0 : LN'($urandom);
    if (w) apply_wr(wa, prev_d0, prev_b0);
    e0 = ref_mem[ra];
    @(posedge clk_i); #2;
    chk("R10 echo high on first beat", 32'(echo_o), 32'd1);
    if (r) begin
      chk("R4 R5 oe on first word", 32'(oe_o), 32'd1);
      chk("R4 R9 first word data", 32'(rdata_o), 32'(e0));
    end else chk("R6 oe low when no read pending", 32'(oe_o), 32'd0);
    @(negedge clk_i);
    load_i = 1'($urandom); rw_i = 1'($urandom); addr_i = AW'($urandom); // R1 junk
    wdata_i = w ? prev_d1 : DW'($urandom);
    bw_ni   = w ? prev_b1 : LN'($urandom);
    if (w) apply_wr(pair_of(wa), prev_d1, prev_b1);
    e1 = ref_mem[pair_of(ra)];
    @(posedge clk_i); #2;
    chk("R10 echo low on second beat", 32'(echo_o), 32'd0);
    chk("R6 oe held over second beat", 32'(oe_o), 32'(r));
    if (r) chk("R3 R7 R8 second word data", 32'(rdata_o), 32'(e1));
    prev_rd = ld & rw; prev_wr = ld & ~rw;
    prev_ra = a; prev_wa = a;
    prev_d0 = d0; prev_d1 = d1; prev_b0 = b0; prev_b1 = b1;
  endtask

  task automatic idle();
    run_cycle(1'b0, 1'b0, '0, '0, '0, '1, '1);
  endtask

  initial begin
    #(10 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v0, v1;
    void'($urandom(32'd20250611));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R11 oe low in reset", 32'(oe_o), 32'd0);
    chk("R11 echo low in reset", 32'(echo_o), 32'd0);
    @(posedge clk_i); #2 rst_ni = 1'b1;

    // fill every word (R2 write, R7 late data, full lanes)
    for (int i = 0; i < DEPTH; i += 2)
      run_cycle(1'b1, 1'b0, AW'(i), DW'(i * 1000 + 7), DW'(i * 1000 + 501), '0, '0);
    idle();

    // back-to-back reads, even and odd bases (R3, R5)
    run_cycle(1'b1, 1'b1, AW'(4), '0, '0, '1, '1);
    run_cycle(1'b1, 1'b1, AW'(9), '0, '0, '1, '1);
    run_cycle(1'b1, 1'b1, AW'(10), '0, '0, '1, '1);
    idle(); // R6: last burst completes, then oe drops
    idle();

    // R8 partial lanes, R9 read right after write
    v0 = 18'h2a5a5; v1 = 18'h15a5a;
    run_cycle(1'b1, 1'b0, AW'(12), v0, v1, 2'b01, 2'b10);
    run_cycle(1'b1, 1'b1, AW'(12), '0, '0, '1, '1);
    run_cycle(1'b1, 1'b0, AW'(13), 18'h3ffff, 18'h00001, 2'b11, 2'b00);
    run_cycle(1'b1, 1'b1, AW'(13), '0, '0, '1, '1);
    idle();

    // R11: read in flight when reset hits
    run_cycle(1'b1, 1'b1, AW'(2), '0, '0, '1, '1);
    load_i = 1'b0;
    rst_ni = 1'b0;
    prev_rd = 1'b0; prev_wr = 1'b0;
    repeat (2) @(posedge clk_i);
    #2;
    chk("R11 oe low during reset", 32'(oe_o), 32'd0);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    chk("R11 no output from pre-reset read beat0", 32'(oe_o), 32'd0);
    chk("R11 echo restarts high", 32'(echo_o), 32'd1);
    @(posedge clk_i); #2;
    chk("R11 no output from pre-reset read beat1", 32'(oe_o), 32'd0);

    // random mix (R1, R2, R7, R8, R9)
    for (int n = 0; n < 400; n++)
      run_cycle(($urandom % 4) != 0, 1'($urandom), AW'($urandom),
                DW'($urandom), DW'($urandom), LN'($urandom), LN'($urandom));
    idle();
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule